// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Flag Unit

A bank of lock flags that two independent ports (left and right) share to guard common resources. The flags are separate from any memory array. Each port reaches the bank with a select, a write enable, a flag index and a data bus. Writing a 0 to a flag asks for it. Writing a 1 gives it up, or withdraws a request that is still waiting. Reading a flag tells the port whether it holds the token. A read gives 0 to the holder and 1 to everyone else.

Each flag keeps one request latch per side and a record of its owner. If a port asks for a flag that the other side holds, the request waits. The flag passes to that port on the edge where the holder releases it, so no port ever has to retry. No access stalls. Read data is a combinational function of the stored state and the presented index, and a write takes effect at the next clock edge.

Reset leaves every flag free. Software should still write a 1 to every flag from both sides before first use, so that no stale request survives a warm restart.

Top module: `sem_flag_unit`

## Requirements
- R1: After reset every flag is free, and both ports read all ones at every index.
- R2: A write of 0 to a free flag gives the writing side ownership from the next clock edge. From then on that side reads 0 at that index.
- R3: A read returns 0 only to the side that owns the flag, and the other side reads 1. Both sides never read 0 for the same index at the same time.
- R4: A write of 0 to a flag owned by the other side leaves it owned by the other side. The request is held as pending, and the requester keeps reading 1.
- R5: When the owner writes 1 while the other side has a pending request, the other side owns the flag from the next edge and reads 0.
- R6: When both sides write 0 to the same free flag in the same cycle, the left side becomes the owner and the right request stays pending.
- R7: Only bit 0 of the write data is used. Bits above it have no effect on the flag.
- R8: A read drives the flag value on every data bit.
- R9: A write of 1 by a side that does not own the flag withdraws that side's pending request. Once both sides have written 1, the flag is free with no owner and no pending request.
- R10: An access to one index does not change any other flag. An access with the write enable low changes no flag.
- R11: The read data shows the flag at the presented index in the same cycle, with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lSel | input | 1 | Left semaphore access select |
| lWr | input | 1 | Left write enable (0 = read) |
| lIdx | input | IDX_W | Left flag index |
| lWdata | input | DATA_W | Left write data (bit 0 used) |
| lRdata | output | DATA_W | Left read data (flag value on every bit) |
| rSel | input | 1 | Right semaphore access select |
| rWr | input | 1 | Right write enable (0 = read) |
| rIdx | input | IDX_W | Right flag index |
| rWdata | input | DATA_W | Right write data (bit 0 used) |
| rRdata | output | DATA_W | Right read data (flag value on every bit) |

## Verification
The bench builds the unit with NUM_FLAGS = 8 and DATA_W = 4. With eight flags the full index space is swept after reset and after the directed sequences. A 4-bit bus is wide enough to show that the upper write bits are ignored and that the read value is copied onto every bit. A long pseudo-random run then drives both ports, often at the same index, so that contested requests, handoffs and withdrawals are all reached. Each read is compared against an ownership model that the bench computes from the requirements.

// File: rtl/semaphore_pkg.sv
package semaphore_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Per-flag strobes issued by the control to the flag bank.
  typedef struct packed {
    logic reqLeft;
    logic relLeft;
    logic reqRight;
    logic relRight;
  } flagStrobe_t;

endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import semaphore_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = 3
) (
  input  logic                           lSel,
  input  logic                           lWr,
  input  logic [IDX_W-1:0]               lIdx,
  input  logic                           lBit,
  input  logic                           rSel,
  input  logic                           rWr,
  input  logic [IDX_W-1:0]               rIdx,
  input  logic                           rBit,
  output flagStrobe_t [NUM_FLAGS-1:0]    strobes
);

  logic lWrite;
  logic rWrite;

  assign lWrite = lSel && lWr;
  assign rWrite = rSel && rWr;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
    logic lHit;
    logic rHit;
    assign lHit = lWrite && (lIdx == IDX_W'(i));
    assign rHit = rWrite && (rIdx == IDX_W'(i));
    assign strobes[i].reqLeft  = lHit && !lBit;
    assign strobes[i].relLeft  = lHit &&  lBit;
    assign strobes[i].reqRight = rHit && !rBit;
    assign strobes[i].relRight = rHit &&  rBit;
  end

endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank
  import semaphore_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = 3,
  parameter int DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  flagStrobe_t [NUM_FLAGS-1:0] strobes,
  input  logic [IDX_W-1:0]            lIdx,
  input  logic [IDX_W-1:0]            rIdx,
  output logic [DATA_W-1:0]           lRdata,
  output logic [DATA_W-1:0]           rRdata
);

  logic [NUM_FLAGS-1:0] leftOwns;
  logic [NUM_FLAGS-1:0] rightOwns;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic   pendLeft, pendRight;
    logic   nxtPendLeft, nxtPendRight;
    owner_e owner, nxtOwner;

    always_comb begin
      nxtPendLeft  = pendLeft;
      nxtPendRight = pendRight;
      if (strobes[i].reqLeft)  nxtPendLeft  = 1'b1;
      if (strobes[i].relLeft)  nxtPendLeft  = 1'b0;
      if (strobes[i].reqRight) nxtPendRight = 1'b1;
      if (strobes[i].relRight) nxtPendRight = 1'b0;

      if (owner == OWN_LEFT && nxtPendLeft)        nxtOwner = OWN_LEFT;
      else if (owner == OWN_RIGHT && nxtPendRight) nxtOwner = OWN_RIGHT;
      else if (nxtPendLeft)                        nxtOwner = OWN_LEFT;
      else if (nxtPendRight)                       nxtOwner = OWN_RIGHT;
      else                                         nxtOwner = OWN_NONE;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pendLeft  <= 1'b0;
        pendRight <= 1'b0;
        owner     <= OWN_NONE;
      end else begin
        pendLeft  <= nxtPendLeft;
        pendRight <= nxtPendRight;
        owner     <= nxtOwner;
      end
    end

    assign leftOwns[i]  = (owner == OWN_LEFT);
    assign rightOwns[i] = (owner == OWN_RIGHT);
  end

  logic lFlag;
  logic rFlag;

  always_comb begin
    lFlag = 1'b1;
    rFlag = 1'b1;
    if (int'(lIdx) < NUM_FLAGS) lFlag = !leftOwns[lIdx];
    if (int'(rIdx) < NUM_FLAGS) rFlag = !rightOwns[rIdx];
  end

  assign lRdata = {DATA_W{lFlag}};
  assign rRdata = {DATA_W{rFlag}};

endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit
  import semaphore_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = (NUM_FLAGS > 2) ? $clog2(NUM_FLAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lSel,
  input  logic              lWr,
  input  logic [IDX_W-1:0]  lIdx,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              rSel,
  input  logic              rWr,
  input  logic [IDX_W-1:0]  rIdx,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata
);

  flagStrobe_t [NUM_FLAGS-1:0] strobes;

  sem_ctrl #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_ctrl (
    .lSel(lSel), .lWr(lWr), .lIdx(lIdx), .lBit(lWdata[0]),
    .rSel(rSel), .rWr(rWr), .rIdx(rIdx), .rBit(rWdata[0]),
    .strobes(strobes)
  );

  sem_flag_bank #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .lIdx(lIdx), .rIdx(rIdx),
    .lRdata(lRdata), .rRdata(rRdata)
  );

endmodule

// File: rtl/sem_flag_unit_chk.sv
module sem_flag_unit_chk #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lSel,
  input logic              lWr,
  input logic [IDX_W-1:0]  lIdx,
  input logic [DATA_W-1:0] lWdata,
  input logic [DATA_W-1:0] lRdata,
  input logic              rSel,
  input logic              rWr,
  input logic [IDX_W-1:0]  rIdx,
  input logic [DATA_W-1:0] rWdata,
  input logic [DATA_W-1:0] rRdata
);

  // R3: never two holders of one flag
  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (lIdx == rIdx) |-> (lRdata[0] || rRdata[0]));

  // R8: flag value replicated on the whole bus
  a_r8_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (lRdata == {DATA_W{lRdata[0]}}) && (rRdata == {DATA_W{rRdata[0]}}));

  // R2: lone request on a free flag is granted at the next edge
  a_r2_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
    (lSel && lWr && !lWdata[0] && !rSel && lIdx == rIdx && lRdata[0] && rRdata[0])
    |=> (lIdx != $past(lIdx) || !lRdata[0]));

  // R6: left wins a same-cycle contest on a free flag
  a_r6_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (lSel && lWr && !lWdata[0] && rSel && rWr && !rWdata[0] &&
     lIdx == rIdx && lRdata[0] && rRdata[0])
    |=> (lIdx != $past(lIdx) || rIdx != $past(rIdx) || (!lRdata[0] && rRdata[0])));

  // R9: owner release with no other access leaves the flag free for it
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lSel && lWr && lWdata[0] && !rSel && !lRdata[0])
    |=> (lIdx != $past(lIdx) || lRdata[0]));

endmodule

bind sem_flag_unit sem_flag_unit_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lSel(lSel), .lWr(lWr), .lIdx(lIdx), .lWdata(lWdata), .lRdata(lRdata),
  .rSel(rSel), .rWr(rWr), .rIdx(rIdx), .rWdata(rWdata), .rRdata(rRdata)
);

// File: tb/sem_flag_unit_bench.sv
`timescale 1ns/1ps
module sem_flag_unit_bench;

  localparam int NF = 8;
  localparam int DW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lSel = 0, lWr = 0, rSel = 0, rWr = 0;
  logic [IW-1:0] lIdx = '0, rIdx = '0;
  logic [DW-1:0] lWdata = '0, rWdata = '0;
  logic [DW-1:0] lRdata, rRdata;

  always #5 clk = ~clk;

  sem_flag_unit #(.NUM_FLAGS(NF), .DATA_W(DW)) u_sem_flag_unit (
    .clk(clk), .rst_n(rst_n),
    .lSel(lSel), .lWr(lWr), .lIdx(lIdx), .lWdata(lWdata), .lRdata(lRdata),
    .rSel(rSel), .rWr(rWr), .rIdx(rIdx), .rWdata(rWdata), .rRdata(rRdata)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model: 0 none, 1 left, 2 right
  int own [NF];
  bit pl [NF];
  bit pr [NF];

  task automatic modelReset();
    for (int i = 0; i < NF; i++) begin own[i] = 0; pl[i] = 0; pr[i] = 0; end
  endtask

  task automatic modelStep();
    for (int i = 0; i < NF; i++) begin
      bit nl = pl[i];
      bit nr = pr[i];
      if (lSel && lWr && int'(lIdx) == i) nl = ~lWdata[0];
      if (rSel && rWr && int'(rIdx) == i) nr = ~rWdata[0];
      if (own[i] == 1 && nl)      own[i] = 1;
      else if (own[i] == 2 && nr) own[i] = 2;
      else if (nl)                own[i] = 1;
      else if (nr)                own[i] = 2;
      else                        own[i] = 0;
      pl[i] = nl;
      pr[i] = nr;
    end
  endtask

  task automatic check(string tag);
    logic [DW-1:0] expL, expR;
    expL = (own[lIdx] == 1) ? '0 : '1;
    expR = (own[rIdx] == 2) ? '0 : '1;
    checks++;
    if (lRdata !== expL) begin
      fails++;
      $display("FAIL %s left idx %0d: got %h expected %h", tag, lIdx, lRdata, expL);
    end
    checks++;
    if (rRdata !== expR) begin
      fails++;
      $display("FAIL %s right idx %0d: got %h expected %h", tag, rIdx, rRdata, expR);
    end
    if (lIdx == rIdx) begin
      checks++;
      if (lRdata[0] == 1'b0 && rRdata[0] == 1'b0) begin
        fails++;
        $display("FAIL R3 both hold idx %0d: got %b/%b expected not both 0",
                 lIdx, lRdata[0], rRdata[0]);
      end
    end
  endtask

  // One cycle: present inputs, check same-cycle read (R11), then clock.
  task automatic cyc(input logic ls, input logic lw, input int li, input logic [DW-1:0] ld,
                     input logic rs, input logic rw, input int ri, input logic [DW-1:0] rd,
                     input string tag);
    lSel = ls; lWr = lw; lIdx = IW'(li); lWdata = ld;
    rSel = rs; rWr = rw; rIdx = IW'(ri); rWdata = rd;
    #1;
    check(tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < NF; i++) cyc(1, 0, i, '0, 1, 0, i, '0, tag);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    sweep("R1");

    // R2/R7: request with upper bits set, bit0 clear
    cyc(1, 1, 3, 4'hE, 0, 0, 0, '0, "R7");
    cyc(1, 0, 3, '0, 1, 0, 3, '0, "R2");
    cyc(1, 0, 3, '0, 1, 0, 3, '0, "R8");
    // R4: right requests while left owns
    cyc(0, 0, 0, '0, 1, 1, 3, 4'h0, "R4");
    cyc(1, 0, 3, '0, 1, 0, 3, '0, "R4");
    // R5: left releases with upper bits clear, bit0 set
    cyc(1, 1, 3, 4'h1, 0, 0, 0, '0, "R5");
    cyc(1, 0, 3, '0, 1, 0, 3, '0, "R5");
    // R10: read-only accesses and other flags unchanged
    cyc(1, 0, 3, '0, 1, 0, 3, '0, "R10");
    sweep("R10");
    // right releases: free
    cyc(0, 0, 0, '0, 1, 1, 3, 4'hF, "R9");
    cyc(1, 0, 3, '0, 1, 0, 3, '0, "R9");
    // R6: simultaneous request on flag 5
    cyc(1, 1, 5, 4'h2, 1, 1, 5, 4'h6, "R6");
    cyc(1, 0, 5, '0, 1, 0, 5, '0, "R6");
    // R9: right withdraws, then left releases; right then granted at once
    cyc(0, 0, 0, '0, 1, 1, 5, 4'h1, "R9");
    cyc(1, 1, 5, 4'h1, 1, 0, 5, '0, "R9");
    cyc(1, 0, 5, '0, 1, 0, 5, '0, "R9");
    cyc(0, 0, 0, '0, 1, 1, 5, 4'h0, "R9");
    cyc(1, 0, 5, '0, 1, 0, 5, '0, "R2");
    sweep("R10");

    // Stress: both ports, frequently colliding indices
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      for (int k = 0; k < 32; k++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r = lfsr;
      cyc(r[0], r[1], int'(r[4:2]) & ((r[5]) ? 7 : 1), r[9:6],
          r[10], r[11], int'(r[14:12]) & ((r[15]) ? 7 : 1), r[19:16], "R3");
    end
    sweep("R10");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule